// File: doc/BRIEF.md
# Indirect Jump Landing-Pad Guard

This block observes the stream of retired instructions of a 32-bit RISC-V style core and enforces forward-edge control-flow integrity. A register-indirect jump (JALR) retires and its source register is not exempt. The guard then expects the next retired instruction to be a landing pad. A landing pad is an AUIPC with destination x0, placed on a 4-byte boundary. Its 20-bit immediate is either zero or equal to the label field held in x7.

If the expectation is broken, the guard raises a software-check exception request for one cycle, with cause 18 and trap value 2. Transfers through x1 or x5 are treated as returns, and transfers through x7 are treated as software-guarded. Neither kind sets the expectation.

When no expectation is pending, a landing pad is a plain no-op and raises nothing. The core supplies the retire strobe, the instruction word, the PC, the decoded rs1 index, the current x7 value and an enable bit.

Top module: `lp_guard`

## Requirements
- R1: After reset `fault_o` is 0, `cause_o` and `tval_o` are 0, and no expectation is pending.
- R2: When tracking is enabled, retiring a JALR (opcode 7'h67, funct3 3'b000) whose `rs1_i` is not 1, 5 or 7 sets the expectation. If the next retired instruction is not a landing pad, a fault follows.
- R3: A JALR retired with `rs1_i` equal to 1 or 5 does not set the expectation.
- R4: A JALR retired with `rs1_i` equal to 7 does not set the expectation.
- R5: A landing pad is an instruction with bits [6:0] = 7'h17 and bits [11:7] = 0, with its label in bits [31:12]. A valid landing pad satisfies a pending expectation without a fault. Any landing pad retired with no expectation pending raises nothing.
- R6: A landing pad with `pc_i[1:0]` not zero, retired while the expectation is pending, faults.
- R7: A landing-pad label of 0 skips the label compare. A nonzero label must equal `label_reg_i[31:12]`, or the retire faults while the expectation is pending.
- R8: While `fault_o` is 1, `cause_o` is 18 and `tval_o` is 2. Otherwise both are 0.
- R9: The next retired instruction clears the expectation, whether it passes or faults. A later non-landing-pad instruction then raises nothing.
- R10: With `en_i` low, no expectation is set and no fault is raised, including for an expectation set earlier.
- R11: A fault appears for exactly one cycle, in the cycle after the clock edge at which the offending instruction retires.
- R12: Cycles with `ret_valid_i` low leave the expectation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Tracking enable |
| ret_valid_i | input | 1 | An instruction retires this cycle |
| instr_i | input | 32 | Retired instruction word |
| pc_i | input | XLEN | PC of the retired instruction |
| rs1_i | input | 5 | Decoded rs1 index of the retired instruction |
| label_reg_i | input | XLEN | Current value of x7 |
| fault_o | output | 1 | Software-check exception request |
| cause_o | output | XLEN | Exception cause code |
| tval_o | output | XLEN | Exception trap value |

## Verification
The only internal state is the pending-expectation bit. If it is wrong, the error shows at the ports on the very next retire. A bit stuck set produces spurious faults on ordinary instructions after a pass. A bit that is lost lets a stray instruction after a tracked jump go unreported. In both cases the error is visible one cycle after that retire edge. The stimulus interleaves bubbles, enable changes, exempt jumps and landing pads of each label and alignment class. Every retire therefore exposes the bit through `fault_o`.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam logic [6:0] OPC_AUIPC = 7'h17;
  localparam logic [6:0] OPC_JALR  = 7'h67;
  localparam int unsigned LBL_W    = 20;
  localparam int unsigned N_EXEMPT = 3;
  localparam logic [4:0] EXEMPT_REGS [N_EXEMPT] = '{5'd1, 5'd5, 5'd7};
  localparam int unsigned CAUSE_SWCHK = 18;
  localparam int unsigned TVAL_LPAD   = 2;

  typedef struct packed {
    logic             is_jalr;
    logic             exempt;
    logic             is_lpad;
    logic [LBL_W-1:0] label;
  } lp_dec_t;
endpackage

// File: rtl/lp_decode.sv
module lp_decode
  import lp_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic [4:0]  rs1_i,
  output lp_dec_t     dec_o
);
  logic [N_EXEMPT-1:0] hit;

  for (genvar g = 0; g < N_EXEMPT; g++) begin : g_exempt
    assign hit[g] = (rs1_i == EXEMPT_REGS[g]);
  end

  always_comb begin
    dec_o.is_jalr = (instr_i[6:0] == OPC_JALR) && (instr_i[14:12] == 3'b000);
    dec_o.exempt  = |hit;
    dec_o.is_lpad = (instr_i[6:0] == OPC_AUIPC) && (instr_i[11:7] == 5'd0);
    dec_o.label   = instr_i[31:12];
  end
endmodule

// File: rtl/lp_arm.sv
module lp_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ret_i,
  input  logic set_i,
  output logic armed_o
);
  // each retire replaces the expectation; bubbles hold it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_o <= 1'b0;
    else if (ret_i) armed_o <= set_i;
  end
endmodule

// File: rtl/lp_check.sv
module lp_check
  import lp_pkg::*;
(
  input  lp_dec_t          dec_i,
  input  logic [1:0]       pc_lo_i,
  input  logic [LBL_W-1:0] reg_lbl_i,
  output logic             viol_o
);
  logic aligned, lbl_ok;

  always_comb begin
    aligned = (pc_lo_i == 2'b00);
    lbl_ok  = (dec_i.label == '0) || (dec_i.label == reg_lbl_i);
    viol_o  = !(dec_i.is_lpad && aligned && lbl_ok);
  end
endmodule

// File: rtl/lp_guard.sv
module lp_guard
  import lp_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned LABEL_LSB = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            ret_valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [4:0]      rs1_i,
  input  logic [XLEN-1:0] label_reg_i,
  output logic            fault_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] tval_o
);
  localparam logic [XLEN-1:0] CAUSE_V = XLEN'(CAUSE_SWCHK);
  localparam logic [XLEN-1:0] TVAL_V  = XLEN'(TVAL_LPAD);

  lp_dec_t dec;
  logic    armed_q, viol, active, set_arm, fault_q;
  logic    unused_bits;

  assign unused_bits = ^{pc_i[XLEN-1:2], label_reg_i};

  lp_decode u_dec (
    .instr_i (instr_i),
    .rs1_i   (rs1_i),
    .dec_o   (dec)
  );

  lp_check u_chk (
    .dec_i     (dec),
    .pc_lo_i   (pc_i[1:0]),
    .reg_lbl_i (label_reg_i[LABEL_LSB +: LBL_W]),
    .viol_o    (viol)
  );

  assign active  = ret_valid_i && en_i;
  assign set_arm = active && dec.is_jalr && !dec.exempt;

  lp_arm u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ret_i   (ret_valid_i),
    .set_i   (set_arm),
    .armed_o (armed_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= active && armed_q && viol;
  end

  assign fault_o = fault_q;
  assign cause_o = fault_q ? CAUSE_V : '0;
  assign tval_o  = fault_q ? TVAL_V  : '0;
endmodule

// File: rtl/lp_guard_chk.sv
module lp_guard_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            ret_valid_i,
  input logic [31:0]     instr_i,
  input logic [4:0]      rs1_i,
  input logic            armed_i,
  input logic            fault_o,
  input logic [XLEN-1:0] cause_o,
  input logic [XLEN-1:0] tval_o
);
  logic jr, act;
  assign jr  = (instr_i[6:0] == 7'h67) && (instr_i[14:12] == 3'b000);
  assign act = ret_valid_i && en_i;

  AST_ARM_TRACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && jr && !(rs1_i inside {5'd1, 5'd5, 5'd7}) |=> armed_i); // R2
  AST_RET_EXEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && (rs1_i == 5'd1 || rs1_i == 5'd5) |=> !armed_i); // R3
  AST_X7_EXEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && rs1_i == 5'd7 |=> !armed_i); // R4
  AST_FAULT_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (cause_o == XLEN'(18)) && (tval_o == XLEN'(2))); // R8
  AST_IDLE_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (cause_o == '0) && (tval_o == '0)); // R8
  AST_CLEAR_ON_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i && !(act && jr) |=> !armed_i); // R9
  AST_NO_FAULT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(en_i)); // R10
  AST_FAULT_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(ret_valid_i) && $past(armed_i)); // R11
  AST_BUBBLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_valid_i |=> $stable(armed_i)); // R12
endmodule

bind lp_guard lp_guard_chk #(.XLEN(XLEN)) u_lp_guard_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .ret_valid_i (ret_valid_i),
  .instr_i     (instr_i),
  .rs1_i       (rs1_i),
  .armed_i     (armed_q),
  .fault_o     (fault_o),
  .cause_o     (cause_o),
  .tval_o      (tval_o)
);

// File: tb/lp_guard_bench.sv
`timescale 1ns/1ps
module lp_guard_bench;
  localparam int XLEN = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0;
  logic            ret_valid_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic [XLEN-1:0] pc_i = '0;
  logic [4:0]      rs1_i = '0;
  logic [XLEN-1:0] label_reg_i = '0;
  logic            fault_o;
  logic [XLEN-1:0] cause_o, tval_o;

  int checks = 0, errors = 0;
  bit m_armed = 1'b0;

  always #10 clk_i = ~clk_i;

  lp_guard #(.XLEN(XLEN)) u_lp_guard (.*);

  function automatic logic [31:0] f_jalr(input logic [4:0] rs1);
    return {12'h010, rs1, 3'b000, 5'd0, 7'h67};
  endfunction
  function automatic logic [31:0] f_lpad(input logic [19:0] lbl);
    return {lbl, 5'd0, 7'h17};
  endfunction
  function automatic bit f_is_jalr(input logic [31:0] w);
    return w[6:0] == 7'h67 && w[14:12] == 3'b000;
  endfunction
  function automatic bit f_viol(input logic [31:0] w, input logic [XLEN-1:0] pc,
                                input logic [XLEN-1:0] x7);
    bit lp = w[6:0] == 7'h17 && w[11:7] == 5'd0;
    bit ok = lp && pc[1:0] == 2'b00 && (w[31:12] == 20'd0 || w[31:12] == x7[31:12]);
    return !ok;
  endfunction

  task automatic check(input string req, input bit exp_f);
    logic [XLEN-1:0] ec = exp_f ? 32'd18 : 32'd0;
    logic [XLEN-1:0] et = exp_f ? 32'd2 : 32'd0;
    checks++;
    if (fault_o !== exp_f || cause_o !== ec || tval_o !== et) begin
      errors++;
      $display("FAIL %s: fault=%0b cause=%0d tval=%0d expected fault=%0b cause=%0d tval=%0d",
               req, fault_o, cause_o, tval_o, exp_f, ec, et);
    end
  endtask

  // drive at negedge, model at posedge, check at next negedge
  task automatic step(input string req, input bit v, input bit en, input logic [31:0] w,
                      input logic [4:0] rs1, input logic [XLEN-1:0] pc,
                      input logic [XLEN-1:0] x7);
    bit exp_f;
    ret_valid_i = v; en_i = en; instr_i = w; rs1_i = rs1; pc_i = pc; label_reg_i = x7;
    @(posedge clk_i);
    exp_f = v && en && m_armed && f_viol(w, pc, x7);
    if (v) m_armed = en && f_is_jalr(w) && !(rs1 inside {5'd1, 5'd5, 5'd7});
    @(negedge clk_i);
    check(req, exp_f);
  endtask

  task automatic bubble(input string req);
    step(req, 1'b0, en_i, 32'h0000_0013, 5'd0, 32'h100, 32'h0);
  endtask

  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [31:0] X7V = 32'hABCDE_000;

  initial begin
    int unused_seed = $urandom(32'd7);
    repeat (3) @(negedge clk_i);
    check("R1", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step("R1", 1'b1, 1'b1, NOP, 5'd0, 32'h100, X7V);

    // R2 tracked jump then non-pad
    step("R2", 1, 1, f_jalr(5'd10), 5'd10, 32'h100, X7V);
    step("R2", 1, 1, NOP, 5'd0, 32'h200, X7V);
    step("R11", 1, 1, NOP, 5'd0, 32'h204, X7V);
    // R3 / R4 exemptions
    step("R3", 1, 1, f_jalr(5'd1), 5'd1, 32'h100, X7V);
    step("R3", 1, 1, NOP, 5'd0, 32'h200, X7V);
    step("R3", 1, 1, f_jalr(5'd5), 5'd5, 32'h100, X7V);
    step("R3", 1, 1, NOP, 5'd0, 32'h200, X7V);
    step("R4", 1, 1, f_jalr(5'd7), 5'd7, 32'h100, X7V);
    step("R4", 1, 1, NOP, 5'd0, 32'h200, X7V);
    // R5 good pad, zero label; R9 cleared afterwards
    step("R5", 1, 1, f_jalr(5'd11), 5'd11, 32'h100, X7V);
    step("R5", 1, 1, f_lpad(20'd0), 5'd0, 32'h200, X7V);
    step("R9", 1, 1, NOP, 5'd0, 32'h204, X7V);
    step("R5", 1, 1, f_lpad(20'h12345), 5'd0, 32'h208, X7V);
    // R7 matching and mismatching label
    step("R7", 1, 1, f_jalr(5'd12), 5'd12, 32'h100, X7V);
    step("R7", 1, 1, f_lpad(20'hABCDE), 5'd0, 32'h200, X7V);
    step("R7", 1, 1, f_jalr(5'd12), 5'd12, 32'h100, X7V);
    step("R7", 1, 1, f_lpad(20'hABCDF), 5'd0, 32'h200, X7V);
    step("R9", 1, 1, NOP, 5'd0, 32'h204, X7V);
    // R6 misaligned pad
    step("R6", 1, 1, f_jalr(5'd13), 5'd13, 32'h100, X7V);
    step("R6", 1, 1, f_lpad(20'd0), 5'd0, 32'h202, X7V);
    // R12 bubbles hold expectation
    step("R12", 1, 1, f_jalr(5'd14), 5'd14, 32'h100, X7V);
    bubble("R12"); bubble("R12"); bubble("R12");
    step("R12", 1, 1, NOP, 5'd0, 32'h200, X7V);
    // R10 enable low
    step("R10", 1, 0, f_jalr(5'd15), 5'd15, 32'h100, X7V);
    step("R10", 1, 1, NOP, 5'd0, 32'h200, X7V);
    step("R10", 1, 1, f_jalr(5'd15), 5'd15, 32'h100, X7V);
    step("R10", 1, 0, NOP, 5'd0, 32'h200, X7V);
    step("R10", 1, 1, NOP, 5'd0, 32'h204, X7V);
    // R8 codes on back-to-back faults
    step("R8", 1, 1, f_jalr(5'd16), 5'd16, 32'h100, X7V);
    step("R8", 1, 1, f_jalr(5'd16), 5'd16, 32'h200, X7V);
    step("R8", 1, 1, NOP, 5'd0, 32'h300, X7V);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom % 10;
      logic [4:0] r = 5'($urandom);
      logic [XLEN-1:0] x7 = $urandom;
      logic [XLEN-1:0] pc = {$urandom} & 32'hFFFF_FFFC;
      bit en = ($urandom % 8) != 0;
      logic [31:0] w;
      if ($urandom % 4 == 0) pc[1:0] = 2'($urandom);
      case (k)
        0, 1, 2: w = f_jalr(r);
        3:       w = f_jalr(5'd1 + 5'(4 * ($urandom % 2)));
        4:       w = f_lpad(20'd0);
        5, 6:    w = f_lpad(x7[31:12]);
        7:       w = f_lpad(20'($urandom));
        default: w = $urandom;
      endcase
      if (k == 3) r = w[19:15];
      else if (f_is_jalr(w)) r = w[19:15];
      step("R2", ($urandom % 5) != 0, en, w, r, pc, x7);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule